// File: doc/BRIEF.md
# Keyed Flash Erase/Program Sequencer

This block sits between a processor's register-write port and a flash macro. It stops stray code from erasing or writing the flash. Software first sets up three target registers: a page, a byte offset and a data byte. It then writes a command code and four key registers in a fixed order. A request goes out on the flash port only when the last key arrives with every earlier key correct and a valid command stored. A wrong key or a key written out of turn wipes the command and the key progress. The software must then restart from the command write.

The flash memory has two regions, and bit 7 of the page register picks between them. The program region uses large sectors (1024 bytes by default). The page index selects a 256-byte window, and its low bits also select the slot within a sector. The data region uses small sectors (256 bytes by default), and the low page bits pick one of eight sectors. An erase addresses the base of the sector. A byte program addresses the exact byte.

The flash port is a request/acknowledge pair. While the request is high and acknowledge is low, the macro applies back-pressure: request, operation, address and data stay frozen. The transfer completes on the first clock edge where both are high.

Top module: `flash_key_sequencer`

## Requirements
- R1: After reset, `fl_req`, `busy` and `done` are low.
- R2: Register addresses are 0 page, 1 offset, 2 data, 3 command, 4 key A, 5 key B, 6 key C and 7 key D. Write command 8'h6E, then key A, B, C and D in that order. Key A's low nibble must be 4'h5, key B must be 8'h0A, key C 8'h09 and key D 8'h06. This issues a byte program with `fl_op`=0 and `fl_wdata` equal to the data register.
- R3: Command 8'hE6 with the same key chain issues an erase with `fl_op`=1. In the program region (page bit 7 = 0), the address is {page[5:0], offset} with the low 10 bits forced to zero. Page bit 6 is ignored.
- R4: When page bit 7 = 1, `fl_region`=1. The address is {page[2:0], offset}, zero-extended. An erase forces the offset bits to zero. Page bits 6..3 are ignored.
- R5: A key written with a wrong value aborts the sequence. The command and the key progress are cleared, so finishing the remaining keys, or the whole key chain without a fresh command, issues nothing.
- R6: A key written out of order aborts the sequence, even when its value is correct.
- R7: A command value other than 8'hE6 or 8'h6E issues nothing when the key chain completes.
- R8: Only the low nibble of key A is compared.
- R9: `fl_req` rises in the cycle after the key D write. Until acknowledge, `fl_req`, `fl_op`, `fl_region`, `fl_addr` and `fl_wdata` hold steady, and `busy` stays high.
- R10: When `fl_ack` is sampled with `fl_req` high, the next cycle shows `fl_req` and `busy` low and `done` high for exactly one cycle. `fl_ack` while idle has no effect.
- R11: Every register write while `busy` is high is ignored.
- R12: Issuing a request clears the command and the key progress. The page, offset and data registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 8 | Register write value |
| busy | output | 1 | Request outstanding |
| done | output | 1 | One-cycle pulse after acknowledge |
| fl_req | output | 1 | Flash request, held until acknowledge |
| fl_op | output | 1 | 1 = sector erase, 0 = byte program |
| fl_region | output | 1 | 1 = data region, 0 = program region |
| fl_addr | output | 14 | Byte or sector-base address within the region |
| fl_wdata | output | 8 | Byte to program |
| fl_ack | input | 1 | Flash macro acknowledge |

## Verification
The bench builds the block with its default parameters:
- 16 program sectors of 1024 bytes, so the address is 14 bits.
- 8 data sectors of 256 bytes.

With these values, a program-region erase must drop both the low page bits and the offset, while a data-region erase drops only the offset. The ignored page bits (bit 6 in the program region, bits 6..3 in the data region) are set in the vectors so that truncation is visible on `fl_addr`. The short request/acknowledge path lets the bench hold off acknowledge for several cycles and drive the whole sequence while busy.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  localparam logic [2:0] RA_PAGE   = 3'd0;
  localparam logic [2:0] RA_OFFSET = 3'd1;
  localparam logic [2:0] RA_DATA   = 3'd2;
  localparam logic [2:0] RA_CMD    = 3'd3;
  localparam logic [2:0] RA_KEY_A  = 3'd4;
  localparam logic [2:0] RA_KEY_B  = 3'd5;
  localparam logic [2:0] RA_KEY_C  = 3'd6;
  localparam logic [2:0] RA_KEY_D  = 3'd7;

  localparam logic [7:0] CMD_ERASE = 8'hE6;
  localparam logic [7:0] CMD_PROG  = 8'h6E;
  localparam logic [3:0] KEY_A_NIB = 4'h5;
  localparam logic [7:0] KEY_B_VAL = 8'h0A;
  localparam logic [7:0] KEY_C_VAL = 8'h09;
  localparam logic [7:0] KEY_D_VAL = 8'h06;

  typedef enum logic [1:0] {
    STG_A = 2'd0,
    STG_B = 2'd1,
    STG_C = 2'd2,
    STG_D = 2'd3
  } key_stage_e;
endpackage

// File: rtl/fseq_target_regs.sv
module fseq_target_regs
  import fseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] page_q,
  output logic [7:0] offset_q,
  output logic [7:0] data_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q   <= '0;
      offset_q <= '0;
      data_q   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        RA_PAGE:   page_q   <= wr_data;
        RA_OFFSET: offset_q <= wr_data;
        RA_DATA:   data_q   <= wr_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fseq_key_chain.sv
module fseq_key_chain
  import fseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       fire,
  output logic       fire_erase
);
  key_stage_e stage_q;
  logic [7:0] cmd_q;
  logic       cmd_ok;

  assign cmd_ok     = (cmd_q == CMD_ERASE) || (cmd_q == CMD_PROG);
  assign fire       = wr_en && (wr_addr == RA_KEY_D) && (wr_data == KEY_D_VAL)
                      && (stage_q == STG_D) && cmd_ok;
  assign fire_erase = (cmd_q == CMD_ERASE);

  // Each key advances the stage only from its own slot; anything else wipes the chain.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= STG_A;
      cmd_q   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        RA_CMD: cmd_q <= wr_data;
        RA_KEY_A:
          if (stage_q == STG_A && wr_data[3:0] == KEY_A_NIB) stage_q <= STG_B;
          else begin stage_q <= STG_A; cmd_q <= '0; end
        RA_KEY_B:
          if (stage_q == STG_B && wr_data == KEY_B_VAL) stage_q <= STG_C;
          else begin stage_q <= STG_A; cmd_q <= '0; end
        RA_KEY_C:
          if (stage_q == STG_C && wr_data == KEY_C_VAL) stage_q <= STG_D;
          else begin stage_q <= STG_A; cmd_q <= '0; end
        RA_KEY_D: begin
          stage_q <= STG_A;
          cmd_q   <= '0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fseq_addr_gen.sv
module fseq_addr_gen #(
  parameter int PROG_SECTORS      = 16,
  parameter int PROG_SECTOR_BYTES = 1024,
  parameter int DATA_SECTORS      = 8,
  parameter int DATA_SECTOR_BYTES = 256,
  parameter int AW                = $clog2(PROG_SECTORS * PROG_SECTOR_BYTES)
) (
  input  logic [7:0]    page,
  input  logic [7:0]    offset,
  input  logic          erase,
  output logic          region,
  output logic [AW-1:0] addr
);
  // Program region: page index picks a 256-byte window, so AW-8 index bits are used.
  localparam int PIW = AW - 8;
  localparam int DSW = (DATA_SECTORS > 1) ? $clog2(DATA_SECTORS) : 1;
  localparam int DOW = $clog2(DATA_SECTOR_BYTES);
  localparam logic [AW-1:0] PMASK = AW'(PROG_SECTOR_BYTES - 1);
  localparam logic [AW-1:0] DMASK = AW'(DATA_SECTOR_BYTES - 1);

  logic [AW-1:0] prog_byte, data_byte;

  assign region    = page[7];
  assign prog_byte = {page[PIW-1:0], offset};
  assign data_byte = (AW'(page[DSW-1:0]) << DOW) | (AW'(offset) & DMASK);

  always_comb begin
    if (region) addr = erase ? (data_byte & ~DMASK) : data_byte;
    else        addr = erase ? (prog_byte & ~PMASK) : prog_byte;
  end
endmodule

// File: rtl/flash_key_sequencer.sv
module flash_key_sequencer #(
  parameter int PROG_SECTORS      = 16,
  parameter int PROG_SECTOR_BYTES = 1024,
  parameter int DATA_SECTORS      = 8,
  parameter int DATA_SECTOR_BYTES = 256,
  localparam int AW = $clog2(PROG_SECTORS * PROG_SECTOR_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [7:0]    wr_data,
  output logic          busy,
  output logic          done,
  output logic          fl_req,
  output logic          fl_op,
  output logic          fl_region,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_wdata,
  input  logic          fl_ack
);
  logic          wr_ok;
  logic [7:0]    page_q, offset_q, data_q;
  logic          fire, fire_erase, tgt_region;
  logic [AW-1:0] tgt_addr;

  assign wr_ok = wr_en && !fl_req;

  fseq_target_regs u_regs (
    .clk, .rst_n, .wr_en(wr_ok), .wr_addr, .wr_data,
    .page_q, .offset_q, .data_q
  );

  fseq_key_chain u_keys (
    .clk, .rst_n, .wr_en(wr_ok), .wr_addr, .wr_data,
    .fire, .fire_erase
  );

  fseq_addr_gen #(
    .PROG_SECTORS(PROG_SECTORS), .PROG_SECTOR_BYTES(PROG_SECTOR_BYTES),
    .DATA_SECTORS(DATA_SECTORS), .DATA_SECTOR_BYTES(DATA_SECTOR_BYTES),
    .AW(AW)
  ) u_addr (
    .page(page_q), .offset(offset_q), .erase(fire_erase),
    .region(tgt_region), .addr(tgt_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fl_req    <= 1'b0;
      fl_op     <= 1'b0;
      fl_region <= 1'b0;
      fl_addr   <= '0;
      fl_wdata  <= '0;
      done      <= 1'b0;
    end else begin
      done <= fl_req && fl_ack;
      if (fl_req) begin
        if (fl_ack) fl_req <= 1'b0;
      end else if (fire) begin
        fl_req    <= 1'b1;
        fl_op     <= fire_erase;
        fl_region <= tgt_region;
        fl_addr   <= tgt_addr;
        fl_wdata  <= data_q;
      end
    end
  end

  assign busy = fl_req;
endmodule

// File: rtl/flash_key_sequencer_chk.sv
module flash_key_sequencer_chk #(
  parameter int PROG_SECTOR_BYTES = 1024,
  parameter int DATA_SECTOR_BYTES = 256,
  parameter int AW                = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic [7:0]    wr_data,
  input logic          busy,
  input logic          done,
  input logic          fl_req,
  input logic          fl_op,
  input logic          fl_region,
  input logic [AW-1:0] fl_addr,
  input logic [7:0]    fl_wdata,
  input logic          fl_ack
);
  localparam logic [AW-1:0] PMASK = AW'(PROG_SECTOR_BYTES - 1);
  localparam logic [AW-1:0] DMASK = AW'(DATA_SECTOR_BYTES - 1);

  AST_ISSUE_ON_KEY_D: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_req) |-> $past(wr_en && wr_addr == 3'd7 && wr_data == 8'h06)); // R2
  AST_PROG_ERASE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && fl_op && !fl_region) |-> ((fl_addr & PMASK) == '0)); // R3
  AST_DATA_ERASE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && fl_op && fl_region) |-> ((fl_addr & DMASK) == '0)); // R4
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && !fl_ack) |=> (fl_req && busy && $stable(fl_op) && $stable(fl_region)
                             && $stable(fl_addr) && $stable(fl_wdata))); // R9
  AST_ACK_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && fl_ack) |=> (!fl_req && !busy && done)); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(fl_req && fl_ack)); // R10
endmodule

bind flash_key_sequencer flash_key_sequencer_chk #(
  .PROG_SECTOR_BYTES(PROG_SECTOR_BYTES),
  .DATA_SECTOR_BYTES(DATA_SECTOR_BYTES),
  .AW(AW)
) u_chk (.*);

// File: tb/flash_key_sequencer_tb.sv
module flash_key_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {page, offset, data, cmd, exp_req, exp_op, exp_region, exp_addr[13:0]}
  localparam logic [48:0] VECS [0:NVEC-1] = '{
    {8'h05, 8'h3C, 8'hA5, 8'h6E, 1'b1, 1'b0, 1'b0, 14'h053C},
    {8'h07, 8'h11, 8'h00, 8'hE6, 1'b1, 1'b1, 1'b0, 14'h0400},
    {8'h83, 8'h7F, 8'h5A, 8'h6E, 1'b1, 1'b0, 1'b1, 14'h037F},
    {8'hFA, 8'h40, 8'h12, 8'hE6, 1'b1, 1'b1, 1'b1, 14'h0200},
    {8'h3F, 8'hFF, 8'hC3, 8'h6E, 1'b1, 1'b0, 1'b0, 14'h3FFF},
    {8'h01, 8'h22, 8'h44, 8'h66, 1'b0, 1'b0, 1'b0, 14'h0000},
    {8'h41, 8'h00, 8'h99, 8'h6E, 1'b1, 1'b0, 1'b0, 14'h0100}
  };

  logic clk = 0, rst_n = 0, wr_en = 0, fl_ack = 0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic busy, done, fl_req, fl_op, fl_region;
  logic [13:0] fl_addr;
  logic [7:0] fl_wdata;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_key_sequencer u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic keys();
    wr(3'd4, 8'h05); wr(3'd5, 8'h0A); wr(3'd6, 8'h09); wr(3'd7, 8'h06);
  endtask

  task automatic setup(input logic [7:0] p, o, d, c);
    wr(3'd0, p); wr(3'd1, o); wr(3'd2, d); wr(3'd3, c);
  endtask

  task automatic ack_and_check(input string tag);
    @(negedge clk); fl_ack = 1;
    @(negedge clk); fl_ack = 0;
    chk({tag, " req low after ack"}, {31'd0, fl_req}, 0);
    chk({tag, " busy low after ack"}, {31'd0, busy}, 0);
    chk({tag, " done pulse"}, {31'd0, done}, 1);
    @(negedge clk);
    chk({tag, " done single cycle"}, {31'd0, done}, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 req", {31'd0, fl_req}, 0);
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 done", {31'd0, done}, 0);
    rst_n = 1;

    // Vector table: R2 R3 R4 R7
    for (int i = 0; i < NVEC; i++) begin
      setup(VECS[i][48:41], VECS[i][40:33], VECS[i][32:25], VECS[i][24:17]);
      keys();
      chk($sformatf("R2/R3/R4/R7 vec%0d req", i), {31'd0, fl_req}, {31'd0, VECS[i][16]});
      if (VECS[i][16]) begin
        chk($sformatf("R2/R3 vec%0d op", i), {31'd0, fl_op}, {31'd0, VECS[i][15]});
        chk($sformatf("R4 vec%0d region", i), {31'd0, fl_region}, {31'd0, VECS[i][14]});
        chk($sformatf("R3/R4 vec%0d addr", i), {18'd0, fl_addr}, {18'd0, VECS[i][13:0]});
        if (!VECS[i][15])
          chk($sformatf("R2 vec%0d wdata", i), {24'd0, fl_wdata}, {24'd0, VECS[i][32:25]});
        ack_and_check($sformatf("R10 vec%0d", i));
      end
    end

    // R5 wrong key value aborts and clears command
    setup(8'h02, 8'h10, 8'h77, 8'h6E);
    wr(3'd4, 8'h05); wr(3'd5, 8'h0B); wr(3'd6, 8'h09); wr(3'd7, 8'h06);
    chk("R5 wrong key B no req", {31'd0, fl_req}, 0);
    keys();
    chk("R5 command cleared by abort", {31'd0, fl_req}, 0);
    wr(3'd3, 8'h6E); keys();
    chk("R5 fresh sequence issues", {31'd0, fl_req}, 1);
    chk("R5 fresh addr", {18'd0, fl_addr}, 32'h0210);
    ack_and_check("R5");

    // R6 correct value out of order aborts
    wr(3'd3, 8'h6E);
    wr(3'd4, 8'h05); wr(3'd6, 8'h09); wr(3'd5, 8'h0A); wr(3'd6, 8'h09); wr(3'd7, 8'h06);
    chk("R6 out of order no req", {31'd0, fl_req}, 0);

    // R8 key A upper nibble ignored
    wr(3'd3, 8'hE6);
    wr(3'd4, 8'hF5); wr(3'd5, 8'h0A); wr(3'd6, 8'h09); wr(3'd7, 8'h06);
    chk("R8 key A upper nibble don't care", {31'd0, fl_req}, 1);
    chk("R8 erase op", {31'd0, fl_op}, 1);
    ack_and_check("R8");

    // R10 ack while idle has no effect
    @(negedge clk); fl_ack = 1;
    @(negedge clk); fl_ack = 0;
    chk("R10 idle ack no done", {31'd0, done}, 0);
    chk("R10 idle ack no req", {31'd0, fl_req}, 0);

    // R9 hold under back-pressure, R11 writes while busy ignored
    setup(8'h05, 8'h10, 8'h33, 8'h6E);
    keys();
    chk("R9 req rises after key D", {31'd0, fl_req}, 1);
    wr(3'd0, 8'h20); wr(3'd2, 8'hEE); wr(3'd3, 8'hE6); keys();
    chk("R9 req held", {31'd0, fl_req}, 1);
    chk("R9 busy held", {31'd0, busy}, 1);
    chk("R11 op unchanged", {31'd0, fl_op}, 0);
    chk("R9 addr held", {18'd0, fl_addr}, 32'h0510);
    chk("R9 wdata held", {24'd0, fl_wdata}, 32'h33);
    ack_and_check("R9");
    chk("R11 busy-time keys did not queue", {31'd0, fl_req}, 0);

    // R12 keys alone after an issue do nothing; target registers retained
    keys();
    chk("R12 command auto-cleared", {31'd0, fl_req}, 0);
    wr(3'd3, 8'h6E); keys();
    chk("R12/R11 page retained", {18'd0, fl_addr}, 32'h0510);
    chk("R12/R11 data retained", {24'd0, fl_wdata}, 32'h33);
    ack_and_check("R12");

    finish_run();
  end
endmodule